// File: doc/BRIEF.md
# Vector Length and Step Controller

This block holds the vector-control state of a small vector-extended processor core: the active vector length, the maximum vector length, a source element step, a destination element step and a vertical-first mode flag. The decoder hands it one of two commands per cycle, already split into fields. The set-length command loads a new maximum, derives a new active length from an immediate or from the loop-counter register, and returns the resulting length to a destination register. The step command advances both element steps by one element at a time.

In vertical-first operation, software runs a group of instructions on one element, issues a step, and loops back. The step wraps both counters to zero when it reaches the active length, leaves vertical-first mode, and can report completion through a 4-bit condition field that a later branch tests. The mode flag is kept as a two-state machine. In the horizontal state (MODE_HORIZ) the flag reads 0, and in the vertical state (MODE_VERT) it reads 1. Transition ENTER_VERT (horizontal to vertical) is taken by a state-changing set-length command that carries the vertical-first option. Transition LEAVE_VERT (vertical to horizontal) is taken by a state-changing set-length command without that option, or by a step that reaches the end. Every other command holds the state.

Top module: `vec_len_ctrl`

## Requirements
- R1: A set-length command with a new maximum (`new_mvl`=1) and the set-length option (`set_len`=1), not in counter mode, writes the immediate `mvl_imm` into both the maximum and the active length, replacing the old values.
- R2: A set-length command that changes state (`new_mvl` or `set_len` set) clears both element steps to zero and sets the vertical-first flag to the value of `vf_opt` (transitions ENTER_VERT / LEAVE_VERT).
- R3: In counter mode (`use_ctr`=1) with `set_len`=1, the active length becomes the smaller of `ctr_val` and the new maximum. Any counter value above the maximum saturates to the maximum.
- R4: A set-length command with `new_mvl`=1 but `set_len`=0 loads the new maximum and truncates the active length to the smaller of the old length and the new maximum.
- R5: A set-length command with `dst_nz`=1 returns the resulting active length, zero-extended, on `res_val` with `res_wr`=1. With `dst_nz`=0, `res_wr` stays 0. A step command never sets `res_wr`.
- R6: A set-length command with neither `new_mvl` nor `set_len` leaves the length, maximum, steps and flag unchanged, and still returns the current length when `dst_nz`=1.
- R7: A step command that does not reach the active length increments the source and destination steps together by one.
- R8: A step command whose incremented value would equal or exceed the active length (including an active length of 0) clears both steps to zero and clears the vertical-first flag.
- R9: A step command that does not reach the end leaves the vertical-first flag unchanged.
- R10: A step command with `rec`=1 produces `cond_valid`=1 and a condition field laid out as bit 3 less-than, bit 2 greater-than, bit 1 equal, bit 0 summary-overflow. The field is 4'b0001 when the step reached the end and 4'b0000 otherwise. A step with `rec`=0, and any set-length command, leaves `cond_valid` at 0.
- R11: The command fields are sampled on the rising edge where `cmd_valid`=1. State and `res_valid` (and `cond_valid` where it applies) appear after that same edge and last one cycle. Without `cmd_valid` nothing changes. Synchronous reset clears all state and outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_step | input | 1 | 1 = step command, 0 = set-length command |
| use_ctr | input | 1 | Set-length takes its length from the counter register |
| new_mvl | input | 1 | Set-length carries a new maximum length |
| set_len | input | 1 | Set-length writes the active length |
| vf_opt | input | 1 | Set-length enters vertical-first mode |
| rec | input | 1 | Step reports a condition field |
| dst_nz | input | 1 | A nonzero destination register is named |
| mvl_imm | input | 7 | Immediate maximum length |
| ctr_val | input | 64 | Counter-register value |
| vl | output | 7 | Active vector length |
| maxvl | output | 7 | Maximum vector length |
| src_step | output | 7 | Source element step |
| dst_step | output | 7 | Destination element step |
| vfirst | output | 1 | Vertical-first flag |
| res_valid | output | 1 | Command completed, one-cycle pulse |
| res_wr | output | 1 | Result is to be written to the destination |
| res_val | output | 64 | Result value |
| cond_valid | output | 1 | Condition field is valid |
| cond | output | 4 | Condition field: LT, GT, EQ, SO from bit 3 down |

## Verification
Every result of this block is due exactly one clock after the edge that samples the command. This covers the length, maximum, both steps, the mode flag, the result pulse and the condition field. The bench therefore drives a command on a falling edge and holds the strobe for one cycle. It then checks all outputs at the next falling edge, after the sampling edge, and so never straddles a clock edge. The idle checks use the same timing: the bench drives fields without the strobe, waits one cycle, and confirms that neither the state nor the pulses moved.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
    typedef enum logic {
        MODE_HORIZ = 1'b0,
        MODE_VERT  = 1'b1
    } vmode_e;

    // condition field bit positions
    localparam int COND_LT = 3;
    localparam int COND_GT = 2;
    localparam int COND_EQ = 1;
    localparam int COND_SO = 0;
endpackage

// File: rtl/vlc_setlen.sv
module vlc_setlen #(
    parameter int CW   = 7,
    parameter int XLEN = 64
) (
    input  logic [CW-1:0]   cur_vl,
    input  logic [CW-1:0]   cur_mvl,
    input  logic            new_mvl,
    input  logic            set_len,
    input  logic            use_ctr,
    input  logic [CW-1:0]   mvl_imm,
    input  logic [XLEN-1:0] ctr_val,
    output logic [CW-1:0]   nxt_vl,
    output logic [CW-1:0]   nxt_mvl,
    output logic            alters
);
    logic [CW-1:0] ctr_sat;

    always_comb begin
        nxt_mvl = new_mvl ? mvl_imm : cur_mvl;
        // R3: counter value saturates at the new maximum
        if (ctr_val > XLEN'(nxt_mvl))
            ctr_sat = nxt_mvl;
        else
            ctr_sat = ctr_val[CW-1:0];
        if (set_len)
            nxt_vl = use_ctr ? ctr_sat : nxt_mvl;
        else if (cur_vl > nxt_mvl)
            nxt_vl = nxt_mvl;        // R4 truncation
        else
            nxt_vl = cur_vl;
        alters = new_mvl | set_len;
    end
endmodule

// File: rtl/vlc_stepper.sv
module vlc_stepper #(
    parameter int CW = 7
) (
    input  logic [CW-1:0] cur_step,
    input  logic [CW-1:0] cur_vl,
    output logic [CW-1:0] nxt_step,
    output logic          at_end
);
    logic [CW:0] inc;

    always_comb begin
        inc    = {1'b0, cur_step} + 1'b1;
        at_end = inc >= {1'b0, cur_vl};
        nxt_step = at_end ? '0 : inc[CW-1:0];
    end
endmodule

// File: rtl/vlc_mode_fsm.sv
module vlc_mode_fsm
    import vlc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go_vert,
    input  logic go_horiz,
    output logic vert
);
    vmode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= MODE_HORIZ;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_HORIZ: if (go_vert)  state_d = MODE_VERT;   // ENTER_VERT
            MODE_VERT:  if (go_horiz) state_d = MODE_HORIZ;  // LEAVE_VERT
            default:    state_d = MODE_HORIZ;
        endcase
    end

    always_comb begin
        vert = (state_q == MODE_VERT);
    end

    // R2
    vf_enter_chk: assert property (@(posedge clk) disable iff (rst)
        go_vert |=> vert);
    // R8
    vf_leave_chk: assert property (@(posedge clk) disable iff (rst)
        go_horiz |=> !vert);
    // R9
    vf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!go_vert && !go_horiz) |=> $stable(vert));
endmodule

// File: rtl/vec_len_ctrl.sv
module vec_len_ctrl
    import vlc_pkg::*;
#(
    parameter int CW   = 7,
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic            cmd_step,
    input  logic            use_ctr,
    input  logic            new_mvl,
    input  logic            set_len,
    input  logic            vf_opt,
    input  logic            rec,
    input  logic            dst_nz,
    input  logic [CW-1:0]   mvl_imm,
    input  logic [XLEN-1:0] ctr_val,
    output logic [CW-1:0]   vl,
    output logic [CW-1:0]   maxvl,
    output logic [CW-1:0]   src_step,
    output logic [CW-1:0]   dst_step,
    output logic            vfirst,
    output logic            res_valid,
    output logic            res_wr,
    output logic [XLEN-1:0] res_val,
    output logic            cond_valid,
    output logic [3:0]      cond
);
    logic [CW-1:0]   vl_q, mvl_q, src_q, dst_q;
    logic [CW-1:0]   sl_vl, sl_mvl, st_nxt;
    logic            sl_alters, st_end;
    logic            do_set, do_step, go_vert, go_horiz, vert;
    logic            res_valid_q, res_wr_q, cond_valid_q;
    logic [XLEN-1:0] res_val_q;
    logic [3:0]      cond_q;

    vlc_setlen #(.CW(CW), .XLEN(XLEN)) u_setlen (
        .cur_vl(vl_q), .cur_mvl(mvl_q), .new_mvl(new_mvl), .set_len(set_len),
        .use_ctr(use_ctr), .mvl_imm(mvl_imm), .ctr_val(ctr_val),
        .nxt_vl(sl_vl), .nxt_mvl(sl_mvl), .alters(sl_alters)
    );

    vlc_stepper #(.CW(CW)) u_stepper (
        .cur_step(src_q), .cur_vl(vl_q), .nxt_step(st_nxt), .at_end(st_end)
    );

    always_comb begin
        do_set   = cmd_valid & ~cmd_step;
        do_step  = cmd_valid &  cmd_step;
        go_vert  = do_set & sl_alters & vf_opt;
        go_horiz = (do_set & sl_alters & ~vf_opt) | (do_step & st_end);
    end

    vlc_mode_fsm u_mode (
        .clk(clk), .rst(rst), .go_vert(go_vert), .go_horiz(go_horiz), .vert(vert)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vl_q <= '0; mvl_q <= '0; src_q <= '0; dst_q <= '0;
        end else if (do_set && sl_alters) begin
            vl_q  <= sl_vl;
            mvl_q <= sl_mvl;
            src_q <= '0;
            dst_q <= '0;
        end else if (do_step) begin
            src_q <= st_nxt;
            dst_q <= st_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_q  <= 1'b0;
            res_wr_q     <= 1'b0;
            res_val_q    <= '0;
            cond_valid_q <= 1'b0;
            cond_q       <= '0;
        end else begin
            res_valid_q  <= cmd_valid;
            res_wr_q     <= do_set & dst_nz;
            res_val_q    <= (do_set & dst_nz) ? XLEN'(sl_vl) : '0;
            cond_valid_q <= do_step & rec;
            cond_q       <= '0;
            if (do_step && rec && st_end) cond_q[COND_SO] <= 1'b1;
        end
    end

    always_comb begin
        vl         = vl_q;
        maxvl      = mvl_q;
        src_step   = src_q;
        dst_step   = dst_q;
        vfirst     = vert;
        res_valid  = res_valid_q;
        res_wr     = res_wr_q;
        res_val    = res_val_q;
        cond_valid = cond_valid_q;
        cond       = cond_q;
    end

    // R7
    step_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (do_step && !st_end) |=> (src_q == $past(src_q) + 1'b1) && (dst_q == src_q));
    // R8
    step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (do_step && st_end) |=> (src_q == '0) && (dst_q == '0) && !vfirst);
    // R3
    vl_bound_chk: assert property (@(posedge clk) disable iff (rst)
        vl_q <= mvl_q);
    // R7
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        (vl_q != '0) |-> (src_q < vl_q));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (do_set && !new_mvl && !set_len) |=> $stable(vl_q) && $stable(mvl_q) && $stable(src_q));
    // R1
    mvl_load_chk: assert property (@(posedge clk) disable iff (rst)
        (do_set && new_mvl) |=> mvl_q == $past(mvl_imm));
    // R10
    cond_chk: assert property (@(posedge clk) disable iff (rst)
        cond_valid_q |-> (cond_q[3:1] == 3'b000));
    // R11
    pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> res_valid_q);
    // R11
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !res_valid_q && !cond_valid_q && $stable(vl_q) && $stable(src_q));
endmodule

// File: tb/vec_len_ctrl_test.sv
module vec_len_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 7;
    localparam int XLEN = 64;

    typedef struct packed {
        logic            stp;
        logic            uctr;
        logic            nmvl;
        logic            slen;
        logic            vf;
        logic            rc;
        logic            dnz;
        logic [6:0]      mvl;
        logic [63:0]     ctr;
        logic [6:0]      e_vl;
        logic [6:0]      e_mvl;
        logic [6:0]      e_step;
        logic            e_vf;
        logic            e_wr;
        logic [6:0]      e_res;
        logic            e_cv;
        logic [3:0]      e_cond;
        logic [7:0]      req;
    } vec_t;

    localparam int NV = 17;
    // columns: stp uctr nmvl slen vf rc dnz mvl ctr | vl mvl step vf wr res cv cond | req
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,7'd10,64'd0,   7'd10,7'd10,7'd0,1'b1,1'b0,7'd0, 1'b0,4'b0000,8'd1},  // R1 R2
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'd0, 64'd0,   7'd10,7'd10,7'd1,1'b1,1'b0,7'd0, 1'b0,4'b0000,8'd7},  // R7
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'd0, 64'd0,   7'd10,7'd10,7'd2,1'b1,1'b0,7'd0, 1'b0,4'b0000,8'd9},  // R9
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,7'd2, 64'd0,   7'd2, 7'd2, 7'd0,1'b1,1'b0,7'd0, 1'b0,4'b0000,8'd2},  // R2
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,7'd0, 64'd0,   7'd2, 7'd2, 7'd1,1'b1,1'b0,7'd0, 1'b1,4'b0000,8'd10}, // R10
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,7'd0, 64'd0,   7'd2, 7'd2, 7'd0,1'b0,1'b0,7'd0, 1'b1,4'b0001,8'd8},  // R8
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,7'd3, 64'd0,   7'd3, 7'd3, 7'd0,1'b1,1'b0,7'd0, 1'b0,4'b0000,8'd1},  // R1
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,7'd0, 64'd0,   7'd3, 7'd3, 7'd1,1'b1,1'b0,7'd0, 1'b1,4'b0000,8'd7},  // R7
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,7'd0, 64'd0,   7'd3, 7'd3, 7'd2,1'b1,1'b0,7'd0, 1'b1,4'b0000,8'd9},  // R9
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,7'd10,64'd5,   7'd5, 7'd10,7'd0,1'b0,1'b1,7'd5, 1'b0,4'b0000,8'd3},  // R3
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,7'd10,64'h1000000000, 7'd10,7'd10,7'd0,1'b0,1'b1,7'd10,1'b0,4'b0000,8'd3}, // R3
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,7'd2, 64'd0,   7'd2, 7'd2, 7'd0,1'b0,1'b1,7'd2, 1'b0,4'b0000,8'd4},  // R4
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,7'd99,64'd77,  7'd2, 7'd2, 7'd0,1'b0,1'b1,7'd2, 1'b0,4'b0000,8'd6},  // R6
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,7'd127,64'd0,  7'd127,7'd127,7'd0,1'b0,1'b1,7'd127,1'b0,4'b0000,8'd5}, // R5
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,7'd20,64'd20,  7'd20,7'd20,7'd0,1'b0,1'b1,7'd20,1'b0,4'b0000,8'd3},  // R3
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,7'd0, 64'd0,   7'd20,7'd20,7'd1,1'b0,1'b0,7'd0, 1'b0,4'b0000,8'd5},  // R5
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,7'd5, 64'd0,   7'd20,7'd20,7'd1,1'b0,1'b1,7'd20,1'b0,4'b0000,8'd6}   // R6
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cmd_valid = 1'b0, cmd_step = 1'b0, use_ctr = 1'b0, new_mvl = 1'b0;
    logic            set_len = 1'b0, vf_opt = 1'b0, rec = 1'b0, dst_nz = 1'b0;
    logic [CW-1:0]   mvl_imm = '0;
    logic [XLEN-1:0] ctr_val = '0;
    logic [CW-1:0]   vl, maxvl, src_step, dst_step;
    logic            vfirst, res_valid, res_wr, cond_valid;
    logic [XLEN-1:0] res_val;
    logic [3:0]      cond;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_len_ctrl #(.CW(CW), .XLEN(XLEN)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_step(cmd_step),
        .use_ctr(use_ctr), .new_mvl(new_mvl), .set_len(set_len), .vf_opt(vf_opt),
        .rec(rec), .dst_nz(dst_nz), .mvl_imm(mvl_imm), .ctr_val(ctr_val),
        .vl(vl), .maxvl(maxvl), .src_step(src_step), .dst_step(dst_step),
        .vfirst(vfirst), .res_valid(res_valid), .res_wr(res_wr), .res_val(res_val),
        .cond_valid(cond_valid), .cond(cond)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input vec_t v, input logic strobe);
        cmd_valid = strobe;
        cmd_step = v.stp; use_ctr = v.uctr; new_mvl = v.nmvl; set_len = v.slen;
        vf_opt = v.vf; rec = v.rc; dst_nz = v.dnz; mvl_imm = v.mvl; ctr_val = v.ctr;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic chk_vec(input vec_t v);
        string t;
        t = $sformatf("R%0d", v.req);
        chk({t, " vl"},    64'(vl),       64'(v.e_vl));
        chk({t, " maxvl"}, 64'(maxvl),    64'(v.e_mvl));
        chk({t, " src"},   64'(src_step), 64'(v.e_step));
        chk({t, " dst"},   64'(dst_step), 64'(v.e_step));
        chk({t, " vf"},    64'(vfirst),   64'(v.e_vf));
        chk({t, " rvalid R11"}, 64'(res_valid), 64'd1);
        chk({t, " rwr"},   64'(res_wr),   64'(v.e_wr));
        if (v.e_wr) chk({t, " rval"}, res_val, 64'(v.e_res));
        chk({t, " cvalid"}, 64'(cond_valid), 64'(v.e_cv));
        if (v.e_cv) chk({t, " cond"}, 64'(cond), 64'(v.e_cond));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11 reset vl",    64'(vl), 64'd0);
        chk("R11 reset maxvl", 64'(maxvl), 64'd0);
        chk("R11 reset step",  64'(src_step), 64'd0);
        chk("R11 reset vf",    64'(vfirst), 64'd0);
        chk("R11 reset rvalid", 64'(res_valid), 64'd0);
        chk("R11 reset cvalid", 64'(cond_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i], 1'b1);
            chk_vec(VECS[i]);
        end

        // R11: fields without strobe change nothing (state vl=20, step=1)
        v = VECS[0];
        issue(v, 1'b0);
        chk("R11 idle vl",     64'(vl), 64'd20);
        chk("R11 idle step",   64'(src_step), 64'd1);
        chk("R11 idle rvalid", 64'(res_valid), 64'd0);
        chk("R11 idle vf",     64'(vfirst), 64'd0);

        // R10: step without record gives no condition; pulse lasts one cycle
        v = VECS[1];
        issue(v, 1'b1);
        chk("R10 norec cvalid", 64'(cond_valid), 64'd0);
        chk("R7 step to 2", 64'(src_step), 64'd2);
        @(negedge clk);
        chk("R11 pulse end", 64'(res_valid), 64'd0);

        // R8: active length zero, step wraps at once and reports end
        v = VECS[0]; v.mvl = 7'd0; v.vf = 1'b1;
        issue(v, 1'b1);
        chk("R2 vf on zero len", 64'(vfirst), 64'd1);
        v = VECS[5];
        issue(v, 1'b1);
        chk("R8 zero len step", 64'(src_step), 64'd0);
        chk("R8 zero len vf", 64'(vfirst), 64'd0);
        chk("R10 zero len cond", 64'(cond), 64'b0001);

        // R5: step never writes destination even with dst named
        v = VECS[1]; v.dnz = 1'b1;
        issue(v, 1'b1);
        chk("R5 step no write", 64'(res_wr), 64'd0);

        // R2: set-length without vf option leaves vertical mode
        v = VECS[0];
        issue(v, 1'b1);
        v = VECS[1];
        issue(v, 1'b1);
        v = VECS[0]; v.vf = 1'b0; v.mvl = 7'd4;
        issue(v, 1'b1);
        chk("R2 leave vf", 64'(vfirst), 64'd0);
        chk("R2 steps zero", 64'(dst_step), 64'd0);
        chk("R1 vl load", 64'(vl), 64'd4);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule